// File: doc/BRIEF.md
# Video Timing to Stream Bridge

This block accepts parallel video on a single clock. The video consists of a data-enable qualifier, a vertical sync and three colour components per pixel. The block forwards only the pixels inside the active window to a ready/valid stream output. The first pixel of each frame is flagged on `m_tuser`, and the final pixel of each scanline is flagged on `m_tlast`. Each colour component is rescaled from the input width to the output width with its most significant bit aligned. Pixels are then placed on the stream either one or two to a beat. The horizontal sync is not an input: the falling edge of the data-enable already marks the end of each line.

Between the pixel side and the stream side sits an elastic queue of configurable depth, which absorbs downstream stalls. The pixel side can never be paused. If a beat arrives while the queue is full, that beat is discarded and a sticky overflow flag is raised; only a reset clears the flag. The reset input is asynchronous and active-low, and its release is synchronised internally.

Top module: `vid_stream_bridge`

## Requirements
- R1: A beat leaves the block only on a rising clock edge at which `m_tvalid`, `m_tready` and `aclken` are all high; while a beat is offered and not taken, `m_tvalid` stays high and `m_tdata`, `m_tuser` and `m_tlast` hold their values.
- R2: Only pixels sampled with `in_de` high reach the stream, in arrival order, and a line of N pixels yields exactly N beats (one per pixel) or ceil(N/2) beats (two per beat).
- R3: `m_tuser` is high on the single beat carrying the first active pixel after a rising edge of `in_vsync`; a line that arrives after reset before any vertical sync carries no `m_tuser`.
- R4: `m_tlast` is high on exactly one beat per line: the beat carrying the pixel after which `in_de` falls.
- R5: While `rst_n` is low, `m_tvalid` and `overflow` are low, whatever the pixel inputs do.
- R6: When OUT_W exceeds IN_W, each output component is the input component in its top IN_W bits with zeros below (8 to 10 bits gives {c, 2'b00}).
- R7: When OUT_W is below IN_W, each output component is the top OUT_W bits of the input (10 to 8 bits gives c[9:2]).
- R8: Within a pixel slot of 3*OUT_W bits, red occupies the most significant field, then green, then blue in the least significant field; `m_tdata` is PIX_PER_BEAT*3*OUT_W bits wide.
- R9: With two pixels per beat, the earlier pixel of a pair is in bits [3*OUT_W-1:0] and the later one is in the upper half; a line of odd length ends with a beat whose upper half is zero and whose `m_tlast` is high.
- R10: A beat that arrives while the queue holds FIFO_DEPTH beats is discarded, the beats already queued are delivered unchanged, and `overflow` goes high and stays high until reset; without a full queue, `overflow` stays low.
- R11: Under arbitrary `m_tready` and `aclken` stalls that leave the queue room, every pixel is delivered in order and `m_tuser` and `m_tlast` stay attached to their pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and stream clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| aclken | input | 1 | Stream-side clock enable; qualifies transfers |
| in_de | input | 1 | High while the input carries active pixels |
| in_vsync | input | 1 | Vertical sync; its rising edge arms the frame-start marker |
| in_r | input | IN_W | Red component |
| in_g | input | IN_W | Green component |
| in_b | input | IN_W | Blue component |
| m_tready | input | 1 | Downstream ready |
| m_tvalid | output | 1 | Beat available |
| m_tdata | output | PIX_PER_BEAT*3*OUT_W | Packed pixel data |
| m_tuser | output | 1 | Frame-start marker |
| m_tlast | output | 1 | Line-end marker |
| overflow | output | 1 | Sticky flag: a beat was dropped because the queue was full |

## Verification
Two situations are difficult to reach from the ports: a queue overflow, and a frame-start marker that must survive a long stall. To reach both, the bench drops `m_tready` completely and then sends one line that is longer than the queue. For each configuration it predicts exactly which queued beats are kept (the first FIFO_DEPTH beats, including the one marked with `m_tuser`), confirms the sticky flag, and only then releases the stream to drain. The ordinary paths are covered by a sweep of every line length from 1 to 8 over several frames. Two instances run side by side, one widening with one pixel per beat and one narrowing with two pixels per beat, so the sweep exercises both the odd-length padding and the even-length pairing. The same sweep is repeated under pseudo-random ready and clock-enable stalls.

// File: rtl/vsb_pkg.sv
`timescale 1ns/1ps
package vsb_pkg;
  // Number of colour components per pixel slot.
  localparam int unsigned COMP_N = 3;

  // Width of one stream beat for a given packing and component width.
  function automatic int unsigned beat_width(input int unsigned ppb, input int unsigned comp_w);
    return ppb * COMP_N * comp_w;
  endfunction
endpackage

// File: rtl/vsb_comp_scale.sv
`timescale 1ns/1ps
// MSB-aligned rescale of one colour component.
module vsb_comp_scale #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 8
) (
  input  logic [IN_W-1:0]  in_c,
  output logic [OUT_W-1:0] out_c
);
  localparam int unsigned DIFF_W = (OUT_W > IN_W) ? (OUT_W - IN_W) : 1;

  generate
    if (OUT_W > IN_W) begin : g_widen
      assign out_c = {in_c, {DIFF_W{1'b0}}};
    end else if (OUT_W == IN_W) begin : g_same
      assign out_c = in_c;
    end else begin : g_narrow
      assign out_c = in_c[IN_W-1 -: OUT_W];
    end
  endgenerate
endmodule

// File: rtl/vsb_front.sv
`timescale 1ns/1ps
// Captures active pixels, rescales them and tags frame start / line end.
// A pixel is emitted one cycle after capture so the line end is known.
module vsb_front
  import vsb_pkg::*;
#(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_de,
  input  logic                      in_vsync,
  input  logic [IN_W-1:0]           in_r,
  input  logic [IN_W-1:0]           in_g,
  input  logic [IN_W-1:0]           in_b,
  output logic                      px_vld,
  output logic [COMP_N*OUT_W-1:0]   px_data,
  output logic                      px_sof,
  output logic                      px_eol
);
  localparam int unsigned PW = COMP_N * OUT_W;

  logic [IN_W-1:0]  comp_in  [COMP_N];
  logic [OUT_W-1:0] comp_out [COMP_N];
  logic [PW-1:0]    scaled;

  assign comp_in[0] = in_r;
  assign comp_in[1] = in_g;
  assign comp_in[2] = in_b;

  generate
    for (genvar k = 0; k < COMP_N; k++) begin : g_comp
      vsb_comp_scale #(.IN_W(IN_W), .OUT_W(OUT_W)) u_scale (
        .in_c  (comp_in[k]),
        .out_c (comp_out[k])
      );
      // red in the top field, blue in the bottom one
      assign scaled[(COMP_N-1-k)*OUT_W +: OUT_W] = comp_out[k];
    end
  endgenerate

  logic          vs_q,       vs_d;
  logic          sof_pend_q, sof_pend_d;
  logic          hold_vld_q, hold_vld_d;
  logic          hold_sof_q, hold_sof_d;
  logic [PW-1:0] hold_pix_q;
  logic          vs_rise;

  assign vs_rise = in_vsync & ~vs_q;

  always_comb begin
    vs_d       = in_vsync;
    hold_vld_d = in_de;
    hold_sof_d = in_de & (sof_pend_q | vs_rise);
    sof_pend_d = sof_pend_q;
    if (in_de) begin
      sof_pend_d = 1'b0;
    end else if (vs_rise) begin
      sof_pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q       <= 1'b0;
      sof_pend_q <= 1'b0;
      hold_vld_q <= 1'b0;
      hold_sof_q <= 1'b0;
    end else begin
      vs_q       <= vs_d;
      sof_pend_q <= sof_pend_d;
      hold_vld_q <= hold_vld_d;
      hold_sof_q <= hold_sof_d;
    end
  end

  // data register: loaded only on active pixels, no reset needed
  always_ff @(posedge clk) begin
    if (in_de) begin
      hold_pix_q <= scaled;
    end
  end

  assign px_vld  = hold_vld_q;
  assign px_data = hold_pix_q;
  assign px_sof  = hold_sof_q;
  assign px_eol  = ~in_de;

  // R4: a line-end pixel is always followed by a cycle with no pixel
  a_r4_eol_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (px_vld && px_eol) |=> !px_vld);

  // R3: a tagged pixel consumes the pending frame start
  a_r3_sof_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (px_vld && px_sof && !in_vsync) |=> !(px_vld && px_sof));
endmodule

// File: rtl/vsb_pair.sv
`timescale 1ns/1ps
// Packs two consecutive pixels of a line into one beat; the earlier pixel
// goes in the low half. An unpaired last pixel is sent with a zero upper half.
module vsb_pair #(
  parameter int unsigned PW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            px_vld,
  input  logic [PW-1:0]   px_data,
  input  logic            px_sof,
  input  logic            px_eol,
  output logic            beat_vld,
  output logic [2*PW-1:0] beat_data,
  output logic            beat_sof,
  output logic            beat_eol
);
  logic          lo_vld_q, lo_vld_d;
  logic          lo_sof_q, lo_sof_d;
  logic [PW-1:0] lo_pix_q;
  logic          lo_load;

  always_comb begin
    beat_vld  = 1'b0;
    beat_data = {px_data, lo_pix_q};
    beat_sof  = lo_sof_q;
    beat_eol  = px_eol;
    lo_vld_d  = lo_vld_q;
    lo_sof_d  = lo_sof_q;
    lo_load   = 1'b0;
    if (px_vld) begin
      if (lo_vld_q) begin
        beat_vld = 1'b1;
        lo_vld_d = 1'b0;
      end else if (px_eol) begin
        beat_vld  = 1'b1;
        beat_data = {{PW{1'b0}}, px_data};
        beat_sof  = px_sof;
        beat_eol  = 1'b1;
      end else begin
        lo_vld_d = 1'b1;
        lo_sof_d = px_sof;
        lo_load  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_vld_q <= 1'b0;
      lo_sof_q <= 1'b0;
    end else begin
      lo_vld_q <= lo_vld_d;
      lo_sof_q <= lo_sof_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lo_load) begin
      lo_pix_q <= px_data;
    end
  end

  // R9: a line end never leaves half a pair behind
  a_r9_half_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (px_vld && px_eol) |=> !lo_vld_q);

  // R9: a beat built from a single pixel is a line end with zero upper half
  a_r9_odd_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !lo_vld_q) |-> (beat_eol && (beat_data[2*PW-1:PW] == '0)));
endmodule

// File: rtl/vsb_fifo.sv
`timescale 1ns/1ps
// Elastic queue with drop-on-full and a sticky overflow flag.
module vsb_fifo #(
  parameter int unsigned W     = 26,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         ovf
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, wr_d;
  logic [AW:0]  rd_q, rd_d;
  logic         ovf_q, ovf_d;
  logic         full;
  logic         push_ok;
  logic         pop_ok;

  assign empty   = (wr_q == rd_q);
  assign full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  always_comb begin
    wr_d  = wr_q + {{AW{1'b0}}, push_ok};
    rd_d  = rd_q + {{AW{1'b0}}, pop_ok};
    ovf_d = ovf_q | (push & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_q[AW-1:0]] <= din;
    end
  end

  assign dout = mem[rd_q[AW-1:0]];
  assign ovf  = ovf_q;

  // R1: an offered beat that is not taken stays offered and unchanged
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> (!empty && $stable(dout)));

  // R10: overflow never clears outside reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R10: a push into a full queue raises the flag
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovf_q);

  // R10: occupancy never exceeds the depth
  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_q - rd_q) <= (AW+1)'(DEPTH)));
endmodule

// File: rtl/vid_stream_bridge.sv
`timescale 1ns/1ps
module vid_stream_bridge
  import vsb_pkg::*;
#(
  parameter int unsigned IN_W         = 8,
  parameter int unsigned OUT_W        = 8,
  parameter int unsigned PIX_PER_BEAT = 1,
  parameter int unsigned FIFO_DEPTH   = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  aclken,
  input  logic                                  in_de,
  input  logic                                  in_vsync,
  input  logic [IN_W-1:0]                       in_r,
  input  logic [IN_W-1:0]                       in_g,
  input  logic [IN_W-1:0]                       in_b,
  input  logic                                  m_tready,
  output logic                                  m_tvalid,
  output logic [PIX_PER_BEAT*COMP_N*OUT_W-1:0]  m_tdata,
  output logic                                  m_tuser,
  output logic                                  m_tlast,
  output logic                                  overflow
);
  localparam int unsigned PW      = COMP_N * OUT_W;
  localparam int unsigned TDATA_W = beat_width(PIX_PER_BEAT, OUT_W);
  localparam int unsigned ENTRY_W = TDATA_W + 2;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe_q[1];

  logic          px_vld;
  logic [PW-1:0] px_data;
  logic          px_sof;
  logic          px_eol;

  vsb_front #(.IN_W(IN_W), .OUT_W(OUT_W)) u_front (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_de    (in_de),
    .in_vsync (in_vsync),
    .in_r     (in_r),
    .in_g     (in_g),
    .in_b     (in_b),
    .px_vld   (px_vld),
    .px_data  (px_data),
    .px_sof   (px_sof),
    .px_eol   (px_eol)
  );

  logic               beat_vld;
  logic [TDATA_W-1:0] beat_data;
  logic               beat_sof;
  logic               beat_eol;

  generate
    if (PIX_PER_BEAT == 2) begin : g_pair
      vsb_pair #(.PW(PW)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n_s),
        .px_vld    (px_vld),
        .px_data   (px_data),
        .px_sof    (px_sof),
        .px_eol    (px_eol),
        .beat_vld  (beat_vld),
        .beat_data (beat_data),
        .beat_sof  (beat_sof),
        .beat_eol  (beat_eol)
      );
    end else begin : g_single
      assign beat_vld  = px_vld;
      assign beat_data = px_data;
      assign beat_sof  = px_sof;
      assign beat_eol  = px_eol;
    end
  endgenerate

  logic [ENTRY_W-1:0] q_out;
  logic               q_empty;
  logic               pop;

  assign pop = m_tvalid & m_tready & aclken;

  vsb_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n_s),
    .push  (beat_vld),
    .din   ({beat_sof, beat_eol, beat_data}),
    .pop   (pop),
    .dout  (q_out),
    .empty (q_empty),
    .ovf   (overflow)
  );

  assign m_tvalid = ~q_empty;
  assign m_tuser  = q_out[ENTRY_W-1];
  assign m_tlast  = q_out[ENTRY_W-2];
  assign m_tdata  = q_out[TDATA_W-1:0];

  // R1: without aclken the offered beat is not consumed
  a_r1_enable_gate: assert property (@(posedge clk) disable iff (!rst_n_s)
    (m_tvalid && !aclken && !beat_vld) |=> (m_tvalid && $stable(m_tdata)));
endmodule

// File: tb/test_vid_stream_bridge.sv
`timescale 1ns/1ps
module test_vid_stream_bridge;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       aclken;
  logic       tready;
  logic       de;
  logic       vs;
  logic [9:0] r10, g10, b10;

  always #4 clk = ~clk;  // 125 MHz

  // instance 1: 8 -> 10 bits, one pixel per beat
  logic        a_tvalid, a_tuser, a_tlast, a_ovf;
  logic [29:0] a_tdata;
  // instance 2: 10 -> 8 bits, two pixels per beat
  logic        b_tvalid, b_tuser, b_tlast, b_ovf;
  logic [47:0] b_tdata;

  vid_stream_bridge #(.IN_W(8), .OUT_W(10), .PIX_PER_BEAT(1), .FIFO_DEPTH(16)) i_vid_stream_bridge (
    .clk(clk), .rst_n(rst_n), .aclken(aclken), .in_de(de), .in_vsync(vs),
    .in_r(r10[9:2]), .in_g(g10[9:2]), .in_b(b10[9:2]), .m_tready(tready),
    .m_tvalid(a_tvalid), .m_tdata(a_tdata), .m_tuser(a_tuser), .m_tlast(a_tlast),
    .overflow(a_ovf)
  );

  vid_stream_bridge #(.IN_W(10), .OUT_W(8), .PIX_PER_BEAT(2), .FIFO_DEPTH(16)) i_vid_stream_bridge_pair (
    .clk(clk), .rst_n(rst_n), .aclken(aclken), .in_de(de), .in_vsync(vs),
    .in_r(r10), .in_g(g10), .in_b(b10), .m_tready(tready),
    .m_tvalid(b_tvalid), .m_tdata(b_tdata), .m_tuser(b_tuser), .m_tlast(b_tlast),
    .overflow(b_ovf)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  bit    mon_en = 1'b0;
  bit    bp_mode = 1'b0;
  bit    ovf_mode = 1'b0;
  int    ca, cb;
  string ctx = "R2";

  logic [31:0] qa[$];   // {user, last, data30}
  logic [49:0] qb[$];   // {user, last, data48}

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [29:0] pix(input int f, input int l, input int c);
    logic [9:0] r, g, b;
    r = 10'((f * 97 + l * 31 + c * 53 + 5) % 1024);
    g = 10'((f * 211 + l * 17 + c * 149 + 771) % 1024);
    b = 10'((f * 59 + l * 263 + c * 89 + 300) % 1024);
    return {r, g, b};
  endfunction

  // 8-bit input {c, 2'b00} per component, red on top (R6, R8)
  function automatic logic [29:0] scale_a(input logic [29:0] p);
    return {p[29:22], 2'b00, p[19:12], 2'b00, p[9:2], 2'b00};
  endfunction

  // 10-bit input truncated to c[9:2], red on top (R7, R8)
  function automatic logic [23:0] scale_b(input logic [29:0] p);
    return {p[29:22], p[19:12], p[9:2]};
  endfunction

  // stall generator
  logic [15:0] lfsr = 16'hACE1;
  initial begin
    tready = 1'b1;
    aclken = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (ovf_mode) begin
        tready = 1'b0;
        aclken = 1'b1;
      end else if (bp_mode) begin
        tready = (lfsr[1:0] != 2'b00);
        aclken = (lfsr[3:2] != 2'b00);
      end else begin
        tready = 1'b1;
        aclken = 1'b1;
      end
    end
  end

  // output monitor, sampled on the falling edge
  logic [31:0] ea;
  logic [49:0] eb;
  bit          stall_a, stall_b;
  logic [31:0] prev_a;
  logic [49:0] prev_b;

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (stall_a)  // R1
        chk(a_tvalid && ({a_tuser, a_tlast, a_tdata} == prev_a), "R1 A held beat",
            64'({a_tvalid, a_tuser, a_tlast, a_tdata}), 64'({1'b1, prev_a}));
      if (stall_b)  // R1
        chk(b_tvalid && ({b_tuser, b_tlast, b_tdata} == prev_b), "R1 B held beat",
            64'({b_tvalid, b_tuser, b_tlast, b_tdata}), 64'({1'b1, prev_b}));
      if (a_tvalid && tready && aclken) begin
        if (qa.size() == 0) begin
          chk(1'b0, {ctx, " R2 A unexpected beat"}, 64'(a_tdata), 64'd0);
        end else begin
          ea = qa.pop_front();
          chk(a_tdata == ea[29:0], {ctx, " R6 R8 A data"}, 64'(a_tdata), 64'(ea[29:0]));
          chk(a_tuser == ea[31], {ctx, " R3 A tuser"}, 64'(a_tuser), 64'(ea[31]));
          chk(a_tlast == ea[30], {ctx, " R4 A tlast"}, 64'(a_tlast), 64'(ea[30]));
        end
      end
      if (b_tvalid && tready && aclken) begin
        if (qb.size() == 0) begin
          chk(1'b0, {ctx, " R2 B unexpected beat"}, 64'(b_tdata), 64'd0);
        end else begin
          eb = qb.pop_front();
          chk(b_tdata == eb[47:0], {ctx, " R7 R9 B data"}, 64'(b_tdata), 64'(eb[47:0]));
          chk(b_tuser == eb[49], {ctx, " R3 B tuser"}, 64'(b_tuser), 64'(eb[49]));
          chk(b_tlast == eb[48], {ctx, " R4 R9 B tlast"}, 64'(b_tlast), 64'(eb[48]));
        end
      end
      stall_a = a_tvalid && !(tready && aclken);
      stall_b = b_tvalid && !(tready && aclken);
      prev_a  = {a_tuser, a_tlast, a_tdata};
      prev_b  = {b_tuser, b_tlast, b_tdata};
    end else begin
      stall_a = 1'b0;
      stall_b = 1'b0;
    end
  end

  task automatic vsync_pulse();
    @(posedge clk); #1; vs = 1'b1;
    repeat (3) @(posedge clk);
    #1; vs = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic drive_line(input int n, input int f, input int l, input bit first, input int gap);
    logic [29:0] p0, p1;
    logic [23:0] hi;
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      p0 = pix(f, l, c);
      de = 1'b1;
      {r10, g10, b10} = p0;
      if (!ovf_mode || ca < 16) begin
        qa.push_back({first && (c == 0), c == n - 1, scale_a(p0)});
        ca++;
      end
      if ((c % 2) == 0) begin
        if (c + 1 < n) begin
          p1 = pix(f, l, c + 1);
          hi = scale_b(p1);
        end else begin
          hi = 24'd0;
        end
        if (!ovf_mode || cb < 16) begin
          qb.push_back({first && (c == 0), c + 2 >= n, hi, scale_b(p0)});
          cb++;
        end
      end
    end
    @(posedge clk); #1;
    de = 1'b0;
    {r10, g10, b10} = 30'h2AAAAAAA;  // blanking noise, must not appear
    repeat (gap) @(posedge clk);
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((qa.size() != 0 || qb.size() != 0) && t < 4000) begin
      @(posedge clk);
      t++;
    end
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(qa.size() == 0 && qb.size() == 0, {ctx, " R2 all expected beats delivered"},
        64'(qa.size() + qb.size()), 64'd0);
    chk(!a_tvalid && !b_tvalid, {ctx, " R2 no extra beats"}, 64'({a_tvalid, b_tvalid}), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    de    = 1'b0;
    vs    = 1'b0;
    {r10, g10, b10} = '0;

    // R5: pixels during reset produce nothing
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); #1;
      de = (c != 3);
      vs = (c == 1);
      {r10, g10, b10} = pix(7, 7, c);
      @(negedge clk);
      chk(!a_tvalid && !b_tvalid && !a_ovf && !b_ovf, "R5 quiet in reset",
          64'({a_tvalid, b_tvalid, a_ovf, b_ovf}), 64'd0);
    end
    @(posedge clk); #1;
    de = 1'b0;
    vs = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    mon_en = 1'b1;

    // R3: a line before any vertical sync carries no frame start
    ctx = "R3";
    ca = 0; cb = 0;
    drive_line(4, 5, 0, 1'b0, 6);
    drain();

    // R2 R4 R6 R7 R8 R9: every line length 1..8 over several frames
    ctx = "R2";
    for (int f = 0; f < 3; f++) begin
      vsync_pulse();
      for (int l = 0; l < 8; l++) drive_line(l + 1, f, l, l == 0, 6);
    end
    drain();

    // R11: same sweep under random stalls
    ctx = "R11";
    bp_mode = 1'b1;
    for (int f = 3; f < 5; f++) begin
      vsync_pulse();
      for (int l = 0; l < 8; l++) drive_line(8 - l, f, l, l == 0, 20);
    end
    drain();
    bp_mode = 1'b0;
    @(negedge clk);
    chk(!a_ovf && !b_ovf, "R10 no overflow without a full queue", 64'({a_ovf, b_ovf}), 64'd0);

    // R10: stall completely, then overrun the queue with a long line
    ctx = "R10";
    ovf_mode = 1'b1;
    ca = 0; cb = 0;
    repeat (2) @(posedge clk);
    vsync_pulse();
    drive_line(40, 9, 0, 1'b1, 4);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(a_ovf && b_ovf, "R10 overflow raised", 64'({a_ovf, b_ovf}), 64'b11);
    chk(a_tvalid && b_tvalid, "R10 queued beats still offered", 64'({a_tvalid, b_tvalid}), 64'b11);
    ovf_mode = 1'b0;
    drain();
    @(negedge clk);
    chk(a_ovf && b_ovf, "R10 overflow sticky after drain", 64'({a_ovf, b_ovf}), 64'b11);

    // R5: reset clears the flag and the stream
    mon_en = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!a_ovf && !b_ovf && !a_tvalid && !b_tvalid, "R5 reset clears state",
        64'({a_ovf, b_ovf, a_tvalid, b_tvalid}), 64'd0);

    finish_run();
  end
endmodule